// File: doc/BRIEF.md
# Per-Port Snoop and DVM Enable Register Bank

This block holds one 32-bit control register for each of five slave ports of a cache-coherent interconnect. Each register shows whether its port can take snoop requests and distributed virtual memory (DVM) messages. It also holds two enable bits that software writes to let the port issue those requests. A port's capability comes from a per-port strap input, masked by a two-bit global override input. The registers are reached over a simple request port that carries valid, write, address, write data and a secure attribute. A response follows one cycle later.

Secure accesses are always accepted. A non-secure access is accepted only while the non-secure-permit input is high. A refused access gets an error response, returns zero and changes nothing. The block drives each port's enable outputs to its request issue logic. Each output is the stored enable bit masked by the port's current capability, so a later override or strap change takes effect at once without rewriting the register.

Top module: `snoop_en_bank`

## Requirements
- R1: After reset every stored enable is 0, `snoop_en_o` and `dvm_en_o` are all 0, and `rsp_valid` is 0.
- R2: A read returns bit 31 = DVM capability (strap AND NOT `ovr_off[1]`) and bit 30 = snoop capability (strap AND NOT `ovr_off[0]`, forced to 0 on ports 0, 1 and 2). Bits 29 to 2 read 0. Writes to bits 31 to 2 have no effect.
- R3: On a port that supports the capability, a write stores `req_wdata[0]` as the snoop enable and `req_wdata[1]` as the DVM enable, and a later read returns them in bits 0 and 1. A stored 1 enables the request.
- R4: An enable bit for a capability the port lacks reads as 0 and keeps its stored value across writes. This includes the snoop enable on ports 0 to 2.
- R5: While a port's strap input is low, every write to that port is dropped. Raising the strap later does not reveal a value from the dropped write.
- R6: While `ovr_off[0]` is 1, writes to the snoop enable are dropped. While `ovr_off[1]` is 1, writes to the DVM enable are dropped. This also holds when the override rises in the same cycle as the write.
- R7: `snoop_en_o[i]` equals the stored snoop enable of port i AND its current snoop capability. `dvm_en_o[i]` follows the same rule for DVM. Clearing an override restores an enable that was stored earlier.
- R8: A non-secure access while `nsec_allow` is 0 drops its write and gives a response with `rsp_err` = 1 and `rsp_rdata` = 0. While `nsec_allow` is 1, non-secure accesses behave like secure ones.
- R9: Port i sits at address i*0x1000 (addr[15:12] = i, addr[11:0] = 0). Any other address reads 0, ignores writes, and responds with `rsp_err` = 0 unless R8 applies.
- R10: Each cycle with `req_valid` high is followed by exactly one cycle with `rsp_valid` high. Read data reflects the state in the request cycle, and writes return `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Access is secure |
| nsec_allow | input | 1 | Permit non-secure accesses |
| ovr_off | input | 2 | Global override: bit 0 removes snoop capability, bit 1 removes DVM capability |
| acc_strap | input | 5 | Per-port capability strap |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Access refused for security |
| rsp_rdata | output | 32 | Read data |
| snoop_en_o | output | 5 | Effective snoop enable per port |
| dvm_en_o | output | 5 | Effective DVM enable per port |

## Verification
The collision checked most closely is a register write arriving in the same cycle that an override bit rises. In that case the snoop part of the write must be lost while the DVM part is kept. The bench raises `ovr_off[0]` at the negative edge where it also presents a write of 3 to port 4. Its behavioural model applies the override to that same request. The bench then judges the result by the following readback and by `snoop_en_o` after the override is cleared again. A second overlap comes from changing straps or overrides while enables are already stored. For this case, every clock is compared against the masked model outputs.

// File: rtl/snoop_en_pkg.sv
package snoop_en_pkg;
    localparam int REG_W       = 32;
    localparam int DVM_CAP_BIT = 31;
    localparam int SNP_CAP_BIT = 30;
    localparam int DVM_EN_BIT  = 1;
    localparam int SNP_EN_BIT  = 0;

    typedef struct packed {
        logic dvm;
        logic snp;
    } en_pair_t;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [REG_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/snoop_en_decode.sv
module snoop_en_decode #(
    parameter int NPORT  = 5,
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_secure,
    input  logic              nsec_allow,
    output logic [NPORT-1:0]  port_sel,
    output logic              denied
);
    localparam int IDX_W = ADDR_W - PAGE_W;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    logic             allowed;

    assign idx     = req_addr[ADDR_W-1:PAGE_W];
    assign mapped  = (req_addr[PAGE_W-1:0] == '0) && (int'(idx) < NPORT);
    assign allowed = req_secure || nsec_allow;
    assign denied  = req_valid && !allowed;

    for (genvar i = 0; i < NPORT; i++) begin : g_sel
        assign port_sel[i] = req_valid && allowed && mapped && (idx == IDX_W'(i));
    end

    // R9: at most one register is addressed per access
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));

    // R8: a selected register implies the access was permitted
    p_sel_secure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_sel) |-> (req_secure || nsec_allow));
endmodule

// File: rtl/snoop_en_port.sv
module snoop_en_port
    import snoop_en_pkg::*;
#(
    parameter bit CAN_SNOOP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic ovr_snp_off,
    input  logic ovr_dvm_off,
    input  logic wr_en,
    input  logic wr_snp,
    input  logic wr_dvm,
    output logic cap_snp,
    output logic cap_dvm,
    output logic en_snp,
    output logic en_dvm
);
    en_pair_t st_d, st_q;

    assign cap_snp = CAN_SNOOP && strap && !ovr_snp_off;
    assign cap_dvm = strap && !ovr_dvm_off;

    always_comb begin
        st_d = st_q;
        if (wr_en && strap) begin
            if (cap_snp) st_d.snp = wr_snp;
            if (cap_dvm) st_d.dvm = wr_dvm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_snp = st_q.snp && cap_snp;
    assign en_dvm = st_q.dvm && cap_dvm;

    // R5: with the strap low nothing stored may change
    p_strap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strap |=> $stable(st_q));

    // R6: snoop override freezes the stored snoop enable
    p_ovr_snp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_snp_off |=> $stable(st_q.snp));

    // R6: DVM override freezes the stored DVM enable
    p_ovr_dvm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_dvm_off |=> $stable(st_q.dvm));

    // R4: a port without snoop capability never stores a snoop enable
    p_no_snp_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !CAN_SNOOP |-> !st_q.snp);
endmodule

// File: rtl/snoop_en_bank.sv
module snoop_en_bank
    import snoop_en_pkg::*;
#(
    parameter int              NPORT       = 5,
    parameter int              ADDR_W      = 16,
    parameter int              PAGE_W      = 12,
    parameter logic [NPORT-1:0] SNOOP_PORTS = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic              req_secure,
    input  logic              nsec_allow,
    input  logic [1:0]        ovr_off,
    input  logic [NPORT-1:0]  acc_strap,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic [NPORT-1:0]  snoop_en_o,
    output logic [NPORT-1:0]  dvm_en_o
);
    logic [NPORT-1:0] port_sel;
    logic             denied;
    logic [NPORT-1:0] cap_snp, cap_dvm;
    logic             wdata_unused;
    rsp_t             rsp_d, rsp_q;

    assign wdata_unused = ^req_wdata[REG_W-1:2];

    snoop_en_decode #(
        .NPORT  (NPORT),
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_secure (req_secure),
        .nsec_allow (nsec_allow),
        .port_sel   (port_sel),
        .denied     (denied)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        snoop_en_port #(
            .CAN_SNOOP (SNOOP_PORTS[i])
        ) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .strap       (acc_strap[i]),
            .ovr_snp_off (ovr_off[0]),
            .ovr_dvm_off (ovr_off[1]),
            .wr_en       (port_sel[i] && req_write),
            .wr_snp      (req_wdata[SNP_EN_BIT]),
            .wr_dvm      (req_wdata[DVM_EN_BIT]),
            .cap_snp     (cap_snp[i]),
            .cap_dvm     (cap_dvm[i]),
            .en_snp      (snoop_en_o[i]),
            .en_dvm      (dvm_en_o[i])
        );
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = denied;
        if (!req_write) begin
            for (int i = 0; i < NPORT; i++) begin
                if (port_sel[i]) begin
                    rsp_d.rdata[DVM_CAP_BIT] = cap_dvm[i];
                    rsp_d.rdata[SNP_CAP_BIT] = cap_snp[i];
                    rsp_d.rdata[DVM_EN_BIT]  = dvm_en_o[i];
                    rsp_d.rdata[SNP_EN_BIT]  = snoop_en_o[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    // R10: every request yields a response in the next cycle
    p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10: no response without a request
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: refused access answers with error and zero data
    p_denied_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_secure && !nsec_allow) |=> (rsp_err && rsp_rdata == '0));

    // R9: a misaligned page offset reads zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[PAGE_W-1:0] != '0) |=> (rsp_rdata == '0));

    // R7: a low strap removes both effective enables of that port
    p_strap_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((snoop_en_o | dvm_en_o) & ~acc_strap) == '0);
endmodule

// File: tb/snoop_en_bank_test.sv
module snoop_en_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b1, nsec_allow = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  ovr_off = 2'b00;
    logic [4:0]  acc_strap = 5'b11111;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [4:0]  snoop_en_o, dvm_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit m_snp[5];
    bit m_dvm[5];

    always #5 clk = ~clk;

    snoop_en_bank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
        .nsec_allow(nsec_allow), .ovr_off(ovr_off), .acc_strap(acc_strap),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .snoop_en_o(snoop_en_o), .dvm_en_o(dvm_en_o)
    );

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endfunction

    function automatic bit sup_snp(int p);
        return (p >= 3) && acc_strap[p] && !ovr_off[0];
    endfunction

    function automatic bit sup_dvm(int p);
        return acc_strap[p] && !ovr_off[1];
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic check_outputs;
        logic [4:0] es, ed;
        for (int p = 0; p < 5; p++) begin
            es[p] = m_snp[p] && sup_snp(p);
            ed[p] = m_dvm[p] && sup_dvm(p);
        end
        chk("R7 snoop_en_o", 32'(snoop_en_o), 32'(es));
        chk("R7 dvm_en_o", 32'(dvm_en_o), 32'(ed));
    endtask

    // one bus cycle; reference model evaluated at the request cycle
    task automatic cyc(input bit v, input bit w, input logic [15:0] a,
                       input logic [31:0] d, input bit sec, input string tag);
        bit          ok, mapped, e_err;
        int          p;
        logic [31:0] e_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_secure = sec;
        p      = int'(a[15:12]);
        ok     = sec || nsec_allow;
        mapped = (a[11:0] == 12'h000) && (p < 5);
        e_err  = v && !ok;
        e_rd   = '0;
        if (v && ok && mapped && !w)
            e_rd = {sup_dvm(p), sup_snp(p), 28'h0,
                    m_dvm[p] && sup_dvm(p), m_snp[p] && sup_snp(p)};
        if (v && ok && mapped && w && acc_strap[p]) begin
            if (sup_snp(p)) m_snp[p] = d[0];
            if (sup_dvm(p)) m_dvm[p] = d[1];
        end
        @(posedge clk);
        #1;
        chk({"R10 rsp_valid ", tag}, 32'(rsp_valid), 32'(v));
        chk({"R8 rsp_err ", tag}, 32'(rsp_err), 32'(e_err));
        chk({"rsp_rdata ", tag}, rsp_rdata, e_rd);
        check_outputs();
    endtask

    function automatic logic [15:0] pa(int p);
        return 16'(p * 16'h1000);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 5; p++) begin m_snp[p] = 1'b0; m_dvm[p] = 1'b0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 snoop_en_o after reset", 32'(snoop_en_o), 32'h0);
        chk("R1 dvm_en_o after reset", 32'(dvm_en_o), 32'h0);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);

        for (int p = 0; p < 5; p++) cyc(1, 0, pa(p), 0, 1, "R2 reset readback");
        for (int p = 0; p < 5; p++) cyc(1, 1, pa(p), 32'hFFFF_FFFF, 1, "R3 write all ones");
        for (int p = 0; p < 5; p++) cyc(1, 0, pa(p), 0, 1, "R4 readback after set");
        cyc(0, 0, 0, 0, 1, "R10 idle");
        for (int p = 0; p < 5; p++) cyc(1, 1, pa(p), 32'h0000_0001, 1, "R3 clear dvm");
        for (int p = 0; p < 5; p++) cyc(1, 0, pa(p), 0, 1, "R3 readback");

        // strap low drops writes
        for (int p = 0; p < 5; p++) cyc(1, 1, pa(p), 32'h0, 1, "R3 clear all");
        acc_strap = 5'b01111;
        cyc(1, 1, pa(4), 32'h3, 1, "R5 write strap low");
        cyc(1, 0, pa(4), 0, 1, "R5 read strap low");
        acc_strap = 5'b11111;
        cyc(1, 0, pa(4), 0, 1, "R5 read strap restored");

        // overrides drop writes
        ovr_off = 2'b01;
        cyc(1, 1, pa(3), 32'h3, 1, "R6 snoop override write");
        cyc(1, 0, pa(3), 0, 1, "R6 snoop override read");
        ovr_off = 2'b10;
        cyc(1, 1, pa(3), 32'h0, 1, "R6 dvm override write");
        cyc(1, 0, pa(3), 0, 1, "R6 dvm override read");
        ovr_off = 2'b00;
        cyc(1, 0, pa(3), 0, 1, "R6 read override cleared");

        // override masking of stored enables
        cyc(1, 1, pa(3), 32'h3, 1, "R7 set port3");
        ovr_off = 2'b11;
        cyc(0, 0, 0, 0, 1, "R7 masked");
        ovr_off = 2'b00;
        cyc(0, 0, 0, 0, 1, "R7 restored");
        acc_strap = 5'b10111;
        cyc(1, 0, pa(3), 0, 1, "R7 strap masked read");
        acc_strap = 5'b11111;

        // same-cycle override rise and write
        cyc(1, 1, pa(4), 32'h0, 1, "R6 clear port4");
        ovr_off = 2'b01;
        cyc(1, 1, pa(4), 32'h3, 1, "R6 write as override rises");
        ovr_off = 2'b00;
        cyc(1, 0, pa(4), 0, 1, "R6 read after collision");

        // security gating
        nsec_allow = 1'b0;
        cyc(1, 1, pa(1), 32'h0, 0, "R8 nonsecure write");
        cyc(1, 0, pa(1), 0, 0, "R8 nonsecure read");
        cyc(1, 0, pa(1), 0, 1, "R8 secure read after");
        nsec_allow = 1'b1;
        cyc(1, 1, pa(1), 32'h0, 0, "R8 permitted nonsecure write");
        cyc(1, 0, pa(1), 0, 0, "R8 permitted nonsecure read");
        nsec_allow = 1'b0;

        // address map
        cyc(1, 1, 16'h5000, 32'h3, 1, "R9 write port5");
        cyc(1, 0, 16'h5000, 0, 1, "R9 read port5");
        cyc(1, 1, 16'h2004, 32'h3, 1, "R9 write offset");
        cyc(1, 0, 16'h2004, 0, 1, "R9 read offset");
        cyc(1, 0, pa(2), 0, 1, "R9 read port2 after");
        cyc(1, 1, 16'hF000, 32'h3, 0, "R9 R8 denied unmapped");
        cyc(0, 0, 0, 0, 1, "R10 trailing idle");

        finish_run();
    end
endmodule